// File: doc/BRIEF.md
# Serial Real-Time Clock Slave

This block is a target on a simple synchronous serial bus. It holds a free-running seconds counter, a small array of keep-alive storage words, a snapshot of the counter, two timer words, read-only test words and two control words. The host starts every access by lowering the select line and shifting in a 32-bit command word. The top bit of that word selects a write, the 24-bit register address sits in bits 31:8, and bits 7:0 carry no meaning. A 32-bit data phase follows in the chosen direction. Raising the select line at any point returns the parser to its idle state, so the next access starts with a new command word.

Bits move one per cycle in which `bit_stb` is high, most significant bit first. The host drives `mosi` for that cycle. It reads `miso` before it raises the strobe of the bit it wants. The seconds counter advances once for every `DIV` pulses on `ref_tick`. Only the raw count is held here. Calendar conversion and the host's time bias, which is kept in a storage word, are handled in software.

Top module: `rtc_serial_slave`

## Requirements
- R1: A transfer is 32 command bits followed by 32 data bits, each sent most significant bit first on `bit_stb`. Command bit 31 = 1 means write and 0 means read. The address is bits 31:8 with bit 23 taken as 0, and bits 7:0 are ignored. During a read data phase `miso` shows the selected register MSB first. At all other times `miso` is 0.
- R2: Raising `cs_n` restarts the parser. A write whose 32 data bits did not all arrive changes nothing.
- R3: The counter at address 0x200000 resets to 0 and increments once per `DIV` pulses of `ref_tick`. It wraps from 0xFFFFFFFF to 0.
- R4: A counter write takes effect one cycle after its last data bit. It clears the prescaler, so the next increment comes after `DIV` further pulses. If an increment falls due in the same cycle as the write, the written value wins.
- R5: Addresses 0x200001 to 0x200000+`SRAM_WORDS` are independent read/write storage words.
- R6: Writing 0x204000 stores the counter value held in the cycle the write lands and ignores the data bits. Reading 0x204000 returns the stored value.
- R7: The timer words at 0x210000 and 0x210001 and the control word at 0x21000D can be read and written.
- R8: Addresses 0x210004 to 0x210007 read as `TEST_PATTERN` OR'd with address bits 1:0. Writes to them are ignored.
- R9: Address 0x21000C reads the `pwr_unstable` input in bit 11 and the `batt_low` input in bit 9, with all other bits 0. Writes to it are ignored.
- R10: Reads of any address outside the map return 0. Writes to such addresses are ignored.
- R11: After reset, all writable words and the snapshot read 0 and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Prescaler reference pulse, one cycle wide |
| cs_n | input | 1 | Active-low transaction select |
| bit_stb | input | 1 | One serial bit moves in the cycle this is high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| pwr_unstable | input | 1 | Unstable-power status flag |
| batt_low | input | 1 | Low backup battery status flag |

## Verification
A landing write and a counter increment can fall in the same cycle. This matters in two cases: a write to the counter, where the write must beat the increment, and a write to the snapshot, where the snapshot must hold the value from before the increment. The bench aims a `ref_tick` pulse at the cycle after the final data strobe, with the prescaler one pulse short of rolling over. It then reads the counter and the snapshot back and compares them with a model that applies the write first. It also counts the pulses that follow, to confirm the prescaler was cleared.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned BITS_W = 5;

   localparam logic [ADDR_W-1:0] A_COUNT = 24'h200000;
   localparam logic [ADDR_W-1:0] A_STORE = 24'h200001;
   localparam logic [ADDR_W-1:0] A_SNAP  = 24'h204000;
   localparam logic [ADDR_W-1:0] A_TON   = 24'h210000;
   localparam logic [ADDR_W-1:0] A_TOFF  = 24'h210001;
   localparam logic [ADDR_W-1:0] A_TEST  = 24'h210004;
   localparam logic [ADDR_W-1:0] A_STAT  = 24'h21000C;
   localparam logic [ADDR_W-1:0] A_CTRL  = 24'h21000D;

   localparam int unsigned BIT_UNSTABLE = 11;
   localparam int unsigned BIT_BATTLOW  = 9;

   typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_t;

   typedef enum logic [3:0] {
      RK_NONE, RK_COUNT, RK_STORE, RK_SNAP, RK_TON,
      RK_TOFF, RK_TEST, RK_STAT, RK_CTRL
   } reg_kind_t;
endpackage

// File: rtl/rtc_ser_port.sv
module rtc_ser_port
   import rtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              bit_stb,
   input  logic              mosi,
   output logic              miso,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] rd_word,
   output logic              wr_stb,
   output logic [WORD_W-1:0] wr_word
);
   phase_t              phase_q;
   logic [BITS_W-1:0]   bits_q;
   logic [WORD_W-1:0]   shift_q;
   logic                load_q;
   logic [WORD_W-1:0]   shift_in;

   assign shift_in = {shift_q[WORD_W-2:0], mosi};
   assign wr_word  = shift_q;
   assign miso     = (!cs_n && phase_q == PH_DATA && !cmd_wr) ? shift_q[WORD_W-1] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         bits_q   <= '0;
         shift_q  <= '0;
         load_q   <= 1'b0;
         wr_stb   <= 1'b0;
         cmd_wr   <= 1'b0;
         cmd_addr <= '0;
      end else if (cs_n) begin
         phase_q <= PH_CMD;
         bits_q  <= '0;
         load_q  <= 1'b0;
         wr_stb  <= 1'b0;
      end else begin
         load_q <= 1'b0;
         wr_stb <= 1'b0;
         if (load_q) shift_q <= rd_word;
         if (bit_stb) begin
            unique case (phase_q)
               PH_CMD: begin
                  shift_q <= shift_in;
                  bits_q  <= bits_q + 1'b1;
                  if (&bits_q) begin
                     phase_q  <= PH_DATA;
                     cmd_wr   <= shift_in[WORD_W-1];
                     cmd_addr <= {1'b0, shift_in[WORD_W-2:WORD_W-ADDR_W]};
                     load_q   <= !shift_in[WORD_W-1];
                  end
               end
               PH_DATA: begin
                  shift_q <= shift_in;
                  bits_q  <= bits_q + 1'b1;
                  if (&bits_q) begin
                     phase_q <= PH_DONE;
                     wr_stb  <= cmd_wr;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2
   cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (phase_q == PH_CMD && bits_q == '0 && !wr_stb));

   // R1
   no_stb_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |-> !bit_stb);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
   import rtc_pkg::*;
#(
   parameter int unsigned DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              ld,
   input  logic [WORD_W-1:0] ld_val,
   output logic [WORD_W-1:0] count
);
   localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rtc_sec_counter: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre_q;
   logic          roll;

   assign roll = ref_tick && (pre_q == PRE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         count <= '0;
      end else if (ld) begin
         pre_q <= '0;
         count <= ld_val;
      end else if (ref_tick) begin
         pre_q <= roll ? '0 : pre_q + 1'b1;
         if (roll) count <= count + 1'b1;
      end
   end

   // R3
   step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && roll) |=> count == $past(count) + 32'd1);

   // R3
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !ref_tick) |=> $stable(count));

   // R4
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (count == $past(ld_val) && pre_q == '0));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int unsigned       SRAM_WORDS   = 16,
   parameter logic [WORD_W-1:0] TEST_PATTERN = 32'hC0DE_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_stb,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [WORD_W-1:0] count,
   input  logic              pwr_unstable,
   input  logic              batt_low,
   output logic [WORD_W-1:0] rd_word,
   output logic              cnt_ld,
   output logic [WORD_W-1:0] cnt_ld_val
);
   localparam int unsigned IW = $clog2(SRAM_WORDS);
   localparam logic [ADDR_W-1:0] STORE_LAST = A_STORE + ADDR_W'(SRAM_WORDS - 1);

   generate
      if (SRAM_WORDS < 2 || SRAM_WORDS > 16) begin : g_bad_words
         $error("rtc_regfile: SRAM_WORDS must lie in 2..16");
      end
   endgenerate

   reg_kind_t         kind;
   logic [IW-1:0]     idx;
   logic [WORD_W-1:0] store_q [SRAM_WORDS];
   logic [WORD_W-1:0] snap_q, ton_q, toff_q, ctrl_q;
   logic [WORD_W-1:0] stat_word;

   always_comb begin
      kind = RK_NONE;
      idx  = IW'(addr - A_STORE);
      if (addr == A_COUNT)                           kind = RK_COUNT;
      else if (addr >= A_STORE && addr <= STORE_LAST) kind = RK_STORE;
      else if (addr == A_SNAP)                       kind = RK_SNAP;
      else if (addr == A_TON)                        kind = RK_TON;
      else if (addr == A_TOFF)                       kind = RK_TOFF;
      else if (addr[ADDR_W-1:2] == A_TEST[ADDR_W-1:2]) kind = RK_TEST;
      else if (addr == A_STAT)                       kind = RK_STAT;
      else if (addr == A_CTRL)                       kind = RK_CTRL;
   end

   always_comb begin
      stat_word = '0;
      stat_word[BIT_UNSTABLE] = pwr_unstable;
      stat_word[BIT_BATTLOW]  = batt_low;
   end

   always_comb begin
      unique case (kind)
         RK_COUNT: rd_word = count;
         RK_STORE: rd_word = store_q[idx];
         RK_SNAP:  rd_word = snap_q;
         RK_TON:   rd_word = ton_q;
         RK_TOFF:  rd_word = toff_q;
         RK_TEST:  rd_word = TEST_PATTERN | WORD_W'(addr[1:0]);
         RK_STAT:  rd_word = stat_word;
         RK_CTRL:  rd_word = ctrl_q;
         default:  rd_word = '0;
      endcase
   end

   assign cnt_ld     = wr_stb && (kind == RK_COUNT);
   assign cnt_ld_val = wr_word;

   genvar gi;
   generate
      for (gi = 0; gi < SRAM_WORDS; gi++) begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) store_q[gi] <= '0;
            else if (wr_stb && kind == RK_STORE && idx == IW'(gi)) store_q[gi] <= wr_word;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         ton_q  <= '0;
         toff_q <= '0;
         ctrl_q <= '0;
      end else if (wr_stb) begin
         unique case (kind)
            RK_SNAP: snap_q <= count;
            RK_TON:  ton_q  <= wr_word;
            RK_TOFF: toff_q <= wr_word;
            RK_CTRL: ctrl_q <= wr_word;
            default: ;
         endcase
      end
   end

   // R6
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && kind == RK_SNAP) |=> snap_q == $past(count));

   // R8 R9 R10
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (kind == RK_TEST || kind == RK_STAT || kind == RK_NONE))
      |=> ($stable(ctrl_q) && $stable(ton_q) && $stable(toff_q) && $stable(snap_q)));
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
   import rtc_pkg::*;
#(
   parameter int unsigned       DIV          = 32768,
   parameter int unsigned       SRAM_WORDS   = 16,
   parameter logic [WORD_W-1:0] TEST_PATTERN = 32'hC0DE_0000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic cs_n,
   input  logic bit_stb,
   input  logic mosi,
   output logic miso,
   input  logic pwr_unstable,
   input  logic batt_low
);
   logic              cmd_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [WORD_W-1:0] rd_word, wr_word, count, cnt_ld_val;
   logic              wr_stb, cnt_ld;

   rtc_ser_port u_port (
      .clk, .rst_n, .cs_n, .bit_stb, .mosi, .miso,
      .cmd_wr, .cmd_addr, .rd_word, .wr_stb, .wr_word
   );

   rtc_regfile #(.SRAM_WORDS(SRAM_WORDS), .TEST_PATTERN(TEST_PATTERN)) u_regs (
      .clk, .rst_n, .addr(cmd_addr), .wr_stb, .wr_word, .count,
      .pwr_unstable, .batt_low, .rd_word, .cnt_ld, .cnt_ld_val
   );

   rtc_sec_counter #(.DIV(DIV)) u_secs (
      .clk, .rst_n, .ref_tick, .ld(cnt_ld), .ld_val(cnt_ld_val), .count
   );

   // R1
   miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || cmd_wr) |-> !miso);
endmodule

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
   localparam int unsigned DIV = 4;
   localparam logic [31:0] TP  = 32'h7E57_0000;

   logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, cs_n = 1'b1;
   logic bit_stb = 1'b0, mosi = 1'b0, pwr_u = 1'b0, batt_l = 1'b0;
   logic miso;

   always #10 clk = ~clk;

   rtc_serial_slave #(.DIV(DIV), .SRAM_WORDS(16), .TEST_PATTERN(TP)) dut (
      .clk, .rst_n, .ref_tick, .cs_n, .bit_stb, .mosi, .miso,
      .pwr_unstable(pwr_u), .batt_low(batt_l)
   );

   int n_cmp = 0, n_bad = 0;
   logic [31:0] m_cnt, m_snap, m_ton, m_toff, m_ctrl;
   logic [31:0] m_store [16];
   int m_pre;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [23:0] a);
      logic [31:0] s;
      if (a == 24'h200000) return m_cnt;
      if (a >= 24'h200001 && a <= 24'h200010) return m_store[a - 24'h200001];
      if (a == 24'h204000) return m_snap;
      if (a == 24'h210000) return m_ton;
      if (a == 24'h210001) return m_toff;
      if (a >= 24'h210004 && a <= 24'h210007) return TP | {30'd0, a[1:0]};
      if (a == 24'h21000C) begin
         s = '0; s[11] = pwr_u; s[9] = batt_l; return s;
      end
      if (a == 24'h21000D) return m_ctrl;
      return 32'd0;
   endfunction

   function automatic void model_tick();
      if (m_pre == DIV - 1) begin m_pre = 0; m_cnt = m_cnt + 1; end
      else m_pre++;
   endfunction

   function automatic void model_write(input logic [23:0] a, input logic [31:0] d);
      if (a == 24'h200000) begin m_cnt = d; m_pre = 0; end
      else if (a >= 24'h200001 && a <= 24'h200010) m_store[a - 24'h200001] = d;
      else if (a == 24'h204000) m_snap = m_cnt;
      else if (a == 24'h210000) m_ton = d;
      else if (a == 24'h210001) m_toff = d;
      else if (a == 24'h21000D) m_ctrl = d;
   endfunction

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ref_tick = 1'b1;
         @(negedge clk) ref_tick = 1'b0;
         model_tick();
      end
   endtask

   task automatic send_bit(input logic b, input logic tk, output logic r);
      @(negedge clk);
      r = miso; mosi = b; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0; ref_tick = tk;
      @(negedge clk);
      ref_tick = 1'b0;
      @(negedge clk);
   endtask

   // nd = number of data bits sent; tk = aim a reference pulse at the landing cycle
   task automatic xfer(input logic wr, input logic [23:0] a, input logic [31:0] d,
                       input int nd, input logic tk, output logic [31:0] rd);
      logic [31:0] cmd;
      logic r;
      cmd = {wr, a[22:0], 8'hA5};
      rd = '0;
      @(negedge clk) cs_n = 1'b0;
      for (int i = 31; i >= 0; i--) send_bit(cmd[i], 1'b0, r);
      for (int i = 31; i >= 32 - nd; i--) begin
         send_bit(d[i], (tk && i == 0), r);
         rd[i] = r;
      end
      @(negedge clk) cs_n = 1'b1;
      repeat (2) @(negedge clk);
      if (wr && nd == 32) model_write(a, d);
      if (tk) begin
         if (a == 24'h200000) m_pre = 0; else model_tick();
      end
   endtask

   task automatic rd_chk(input string tag, input logic [23:0] a);
      logic [31:0] v;
      xfer(1'b0, a, 32'h0, 32, 1'b0, v);
      check(tag, v, exp_read(a));
   endtask

   function automatic logic [23:0] pick_addr(input int unsigned r);
      case (r % 12)
         0:  return 24'h200000;
         1, 2, 3: return 24'h200001 + 24'(r % 16);
         4:  return 24'h204000;
         5:  return 24'h210000;
         6:  return 24'h210001;
         7:  return 24'h210004 + 24'(r % 4);
         8:  return 24'h21000C;
         9:  return 24'h21000D;
         10: return 24'h200011;
         default: return 24'h210002;
      endcase
   endfunction

   bit done = 0;
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      m_cnt = 0; m_snap = 0; m_ton = 0; m_toff = 0; m_ctrl = 0; m_pre = 0;
      for (int i = 0; i < 16; i++) m_store[i] = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 reset state
      check("R11 miso idle", {31'd0, miso}, 32'd0);
      rd_chk("R11 counter", 24'h200000);
      rd_chk("R11 store", 24'h200004);
      rd_chk("R11 snapshot", 24'h204000);
      rd_chk("R11 ctrl", 24'h21000D);

      // R3 counting and R1 framing
      tick(DIV * 3 + 2);
      rd_chk("R3 count after pulses", 24'h200000);
      xfer(1'b1, 24'h200000, 32'hFFFF_FFFF, 32, 1'b0, v);
      tick(DIV - 1);
      rd_chk("R4 prescaler restarted", 24'h200000);
      tick(1);
      rd_chk("R3 wrap to zero", 24'h200000);

      // R5 storage, R7 timers/control
      xfer(1'b1, 24'h200004, 32'h1234_5678, 32, 1'b0, v);
      xfer(1'b1, 24'h200010, 32'hCAFE_F00D, 32, 1'b0, v);
      rd_chk("R5 bias word", 24'h200004);
      rd_chk("R5 last word", 24'h200010);
      rd_chk("R5 neighbour untouched", 24'h200005);
      xfer(1'b1, 24'h210000, 32'hAAAA_0001, 32, 1'b0, v);
      xfer(1'b1, 24'h210001, 32'h5555_0002, 32, 1'b0, v);
      xfer(1'b1, 24'h21000D, 32'h0F0F_F0F0, 32, 1'b0, v);
      rd_chk("R7 on timer", 24'h210000);
      rd_chk("R7 off timer", 24'h210001);
      rd_chk("R7 ctrl", 24'h21000D);

      // R8 R9 R10 read-only and unmapped
      xfer(1'b1, 24'h210006, 32'hFFFF_FFFF, 32, 1'b0, v);
      rd_chk("R8 test word 2", 24'h210006);
      rd_chk("R8 test word 3", 24'h210007);
      pwr_u = 1'b1; batt_l = 1'b0;
      rd_chk("R9 unstable bit11", 24'h21000C);
      pwr_u = 1'b0; batt_l = 1'b1;
      xfer(1'b1, 24'h21000C, 32'hFFFF_FFFF, 32, 1'b0, v);
      rd_chk("R9 battery bit9", 24'h21000C);
      xfer(1'b1, 24'h200011, 32'hDEAD_BEEF, 32, 1'b0, v);
      rd_chk("R10 gap read zero", 24'h200011);
      rd_chk("R10 ctrl unchanged", 24'h21000D);
      rd_chk("R10 store untouched", 24'h200010);

      // R2 aborted write
      xfer(1'b1, 24'h200004, 32'h0BAD_0BAD, 16, 1'b0, v);
      rd_chk("R2 partial write dropped", 24'h200004);

      // R4 collision: counter write meets a due increment
      xfer(1'b1, 24'h200000, 32'h0000_0100, 32, 1'b0, v);
      tick(DIV - 1);
      xfer(1'b1, 24'h200000, 32'h0000_0200, 32, 1'b1, v);
      rd_chk("R4 write beats increment", 24'h200000);
      tick(DIV - 1);
      rd_chk("R4 prescaler cleared", 24'h200000);
      tick(1);
      rd_chk("R4 next increment", 24'h200000);

      // R6 snapshot, plain then with a colliding increment
      tick(2);
      xfer(1'b1, 24'h204000, 32'h1111_1111, 32, 1'b0, v);
      rd_chk("R6 snapshot latched", 24'h204000);
      m_pre = m_pre; // model continues
      tick(DIV - 1 - m_pre);
      xfer(1'b1, 24'h204000, 32'h0, 32, 1'b1, v);
      rd_chk("R6 snapshot pre-increment", 24'h204000);
      rd_chk("R6 counter after collision", 24'h200000);

      // random mix
      for (int k = 0; k < 60; k++) begin
         logic [23:0] a;
         logic [31:0] d;
         a = pick_addr($urandom);
         d = $urandom;
         pwr_u = 1'($urandom); batt_l = 1'($urandom);
         tick(int'($urandom % 6));
         if ($urandom % 2) xfer(1'b1, a, d, 32, 1'b0, v);
         else rd_chk("R1 random read", a);
      end
      for (int i = 0; i < 16; i++) rd_chk("R5 final sweep", 24'h200001 + 24'(i));
      rd_chk("R3 final count", 24'h200000);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule